// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets up to four processor cores signal one another with short interrupt messages. Each target core owns one 32-bit message word. Message number m lives at bit 4*m of that word, which gives eight messages per core. A core raises a message by writing a 1 to that bit position in the target core's set word. The receiving core reads its own word, picks out the bit it is handling and writes the same mask to its clear word. Every message bit drives its own interrupt line toward its target core.

Each core has its own 32-bit register port: a byte address, a write strobe, write data and registered read data. So several cores can raise or acknowledge messages in the same clock cycle. Set words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C, one per target core. Clear words sit 0x10 above the matching set word. Read data returns one cycle after the address is presented.

Top module: `ipi_mailbox`

## Requirements
- R1: A synchronous active-high reset clears all message words. While reset is high and on the cycle after it, every interrupt line and every read-data port is zero.
- R2: A write to byte offset 4*c (c below 4) ORs the valid bits of the write data into core c's word. Zero data bits leave the stored bits as they were.
- R3: A write to byte offset 0x10+4*c clears the bits of core c's word where the data is 1. Bits where the data is 0 are kept.
- R4: Only bits 4*m for m = 0..7 are stored (mask 0x11111111). Data at any other bit position is dropped, and those positions always read as zero.
- R5: Reading byte offset 4*c returns core c's word on the read-data port one cycle later, as it stood before any write at that same edge. Reading any clear word returns zero.
- R6: Interrupt line c*8+m is high exactly while bit 4*m of core c's word is set. It changes at the same edge as the word.
- R7: If one port sets a bit and another port clears the same bit in the same cycle, the bit ends up set.
- R8: Sets from several ports to the same core in one cycle all take effect; the result is the OR of their data. Clears from several ports combine the same way.
- R9: An address whose word index (address bits 5:2) is 8 or above hits no register. A write there changes nothing, and a read there returns zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | NUM_CORES*ADDR_W | Byte address per port; port p uses bits [p*ADDR_W +: ADDR_W] |
| bus_we | input | NUM_CORES | Write strobe per port |
| bus_wdata | input | NUM_CORES*32 | Write data per port |
| bus_rdata | output | NUM_CORES*32 | Registered read data per port |
| irq | output | NUM_CORES*NUM_MSGS | Interrupt line for core c, message m at index c*NUM_MSGS+m |

## Verification
A wrong message word shows up on the interrupt lines at the edge where it goes wrong. Because the interrupt lines come straight from the storing flops, the reference model sees the error that same cycle. A word that only stores a bit outside the valid mask shows up only when some port reads that core, one cycle after the read address is presented. For that reason the random traffic reads every port on every cycle. A collision handled in the wrong order between a set from one port and a clear from another leaves a message missing from the line. That is caught at the edge right after the collision.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W        = 32;
  localparam int MSG_STRIDE    = 4;
  localparam int CLR_WORD_BASE = 4;   // clear bank sits 0x10 bytes above set bank

  function automatic logic [WORD_W-1:0] msg_mask(input int num_msgs);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < num_msgs; i++) begin
      if (i * MSG_STRIDE < WORD_W) m[i*MSG_STRIDE] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_MSGS  = 8,
  parameter int ADDR_W    = 6,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [ADDR_W-1:0]                    addr,
  input  logic                                 we,
  input  logic [WORD_W-1:0]                    wdata,
  output logic [NUM_CORES-1:0][WORD_W-1:0]     set_bits,
  output logic [NUM_CORES-1:0][WORD_W-1:0]     clr_bits,
  output logic                                 rd_set_hit,
  output logic                                 rd_clr_hit,
  output logic [CORE_W-1:0]                    rd_core
);
  localparam logic [WORD_W-1:0] VALID = msg_mask(NUM_MSGS);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    rd_set_hit = (int'(word_idx) < NUM_CORES);
    rd_clr_hit = (int'(word_idx) >= CLR_WORD_BASE) &&
                 (int'(word_idx) <  CLR_WORD_BASE + NUM_CORES);
    rd_core    = rd_set_hit ? CORE_W'(word_idx) : CORE_W'(int'(word_idx) - CLR_WORD_BASE);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign set_bits[c] = (we && int'(word_idx) == c) ? (wdata & VALID) : '0;
    assign clr_bits[c] = (we && int'(word_idx) == CLR_WORD_BASE + c) ? (wdata & VALID) : '0;
  end
endmodule

// File: rtl/ipi_msg_reg.sv
module ipi_msg_reg
  import ipi_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_MSGS  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0]  set_in,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0]  clr_in,
  output logic [WORD_W-1:0]                 q
);
  localparam logic [WORD_W-1:0] VALID = msg_mask(NUM_MSGS);

  logic [WORD_W-1:0] set_any, clr_any;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_any = set_any | set_in[p];
      clr_any = clr_any | clr_in[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr_any) | set_any) & VALID;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (q == '0));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_any != '0) |=> ((q & $past(set_any)) == $past(set_any)));
  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_any & ~set_any) != '0) |=> ((q & $past(clr_any & ~set_any)) == '0));
  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (set_any == '0 && clr_any == '0) |=> $stable(q));
  // R4
  valid_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~VALID) == '0);
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              set_hit,
  input  logic                              clr_hit,
  input  logic [CORE_W-1:0]                 core,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  regs,
  output logic [WORD_W-1:0]                 rdata
);
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (set_hit) rdata <= regs[core];
    else              rdata <= '0;
  end

  // R5
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (rdata == '0));
  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_hit && !clr_hit) |=> (rdata == '0));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_MSGS  = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CORES*ADDR_W-1:0]     bus_addr,
  input  logic [NUM_CORES-1:0]            bus_we,
  input  logic [NUM_CORES*32-1:0]         bus_wdata,
  output logic [NUM_CORES*32-1:0]         bus_rdata,
  output logic [NUM_CORES*NUM_MSGS-1:0]   irq
);
  localparam int NUM_PORTS = NUM_CORES;
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  // [port][core] from the decoders, [core][port] into the registers
  logic [NUM_PORTS-1:0][NUM_CORES-1:0][WORD_W-1:0] set_pc, clr_pc;
  logic [NUM_CORES-1:0][NUM_PORTS-1:0][WORD_W-1:0] set_cp, clr_cp;
  logic [NUM_CORES-1:0][WORD_W-1:0]                msg_q;
  logic [NUM_PORTS-1:0]                            rd_set_hit, rd_clr_hit;
  logic [NUM_PORTS-1:0][CORE_W-1:0]                rd_core;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ipi_port_decode #(.NUM_CORES(NUM_CORES), .NUM_MSGS(NUM_MSGS), .ADDR_W(ADDR_W)) u_dec (
      .addr       (bus_addr[p*ADDR_W +: ADDR_W]),
      .we         (bus_we[p]),
      .wdata      (bus_wdata[p*WORD_W +: WORD_W]),
      .set_bits   (set_pc[p]),
      .clr_bits   (clr_pc[p]),
      .rd_set_hit (rd_set_hit[p]),
      .rd_clr_hit (rd_clr_hit[p]),
      .rd_core    (rd_core[p])
    );

    ipi_read_port #(.NUM_CORES(NUM_CORES)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .set_hit (rd_set_hit[p]),
      .clr_hit (rd_clr_hit[p]),
      .core    (rd_core[p]),
      .regs    (msg_q),
      .rdata   (bus_rdata[p*WORD_W +: WORD_W])
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_xpose
      assign set_cp[c][p] = set_pc[p][c];
      assign clr_cp[c][p] = clr_pc[p][c];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_msg_reg #(.NUM_PORTS(NUM_PORTS), .NUM_MSGS(NUM_MSGS)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .set_in (set_cp[c]),
      .clr_in (clr_cp[c]),
      .q      (msg_q[c])
    );

    for (genvar m = 0; m < NUM_MSGS; m++) begin : g_irq
      assign irq[c*NUM_MSGS + m] = msg_q[c][m*MSG_STRIDE];
    end
  end
endmodule

// File: tb/ipi_mailbox_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_tb;
  localparam int NC = 4;
  localparam int NM = 8;
  localparam int AW = 6;
  localparam logic [31:0] VM = 32'h1111_1111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*AW-1:0] bus_addr = '0;
  logic [NC-1:0]    bus_we   = '0;
  logic [NC*32-1:0] bus_wdata = '0;
  logic [NC*32-1:0] bus_rdata;
  logic [NC*NM-1:0] irq;

  always #2.5 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(NC), .NUM_MSGS(NM), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0]   mdl [NC];
  logic [31:0]   exp_rd [NC];
  logic [AW-1:0] a [NC];
  logic          w [NC];
  logic [31:0]   d [NC];
  logic          r_i;

  task automatic idle();
    for (int p = 0; p < NC; p++) begin a[p] = '0; w[p] = 1'b0; d[p] = '0; end
  endtask

  task automatic compare(input string tag);
    logic [NC*NM-1:0] exp_irq;
    for (int p = 0; p < NC; p++) begin
      n_cmp++;
      if (bus_rdata[p*32 +: 32] !== exp_rd[p]) begin
        n_bad++;
        $display("FAIL %s port%0d rdata actual=%h expected=%h", tag, p,
                 bus_rdata[p*32 +: 32], exp_rd[p]);
      end
    end
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < NM; m++) exp_irq[c*NM+m] = mdl[c][4*m];
    n_cmp++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s irq actual=%h expected=%h", tag, irq, exp_irq);
    end
  endtask

  // called at a falling edge; applies a[], w[], d[], r_i for one cycle
  task automatic step(input string tag);
    logic [31:0] sacc [NC];
    logic [31:0] cacc [NC];
    for (int c = 0; c < NC; c++) begin sacc[c] = '0; cacc[c] = '0; end
    for (int p = 0; p < NC; p++) begin
      int wi;
      wi = int'(a[p]) >> 2;
      exp_rd[p] = (r_i || wi >= NC) ? 32'h0 : mdl[wi];
      if (w[p]) begin
        if (wi < NC) sacc[wi] |= d[p];
        else if (wi >= 4 && wi < 4 + NC) cacc[wi-4] |= d[p];
      end
    end
    for (int c = 0; c < NC; c++)
      mdl[c] = r_i ? 32'h0 : (((mdl[c] & ~cacc[c]) | sacc[c]) & VM);
    rst = r_i;
    for (int p = 0; p < NC; p++) begin
      bus_addr[p*AW +: AW] = a[p];
      bus_we[p]            = w[p];
      bus_wdata[p*32 +: 32] = d[p];
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  task automatic wr(input int p, input int addr, input logic [31:0] data);
    a[p] = AW'(addr); w[p] = 1'b1; d[p] = data;
  endtask

  task automatic rd(input int p, input int addr);
    a[p] = AW'(addr); w[p] = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    idle();
    r_i = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    step("R1 reset");
    step("R1 reset");
    r_i = 1'b0;
    step("R1 after reset");

    // R2: set ORs, zero bits no effect
    wr(0, 'h08, 32'h0000_0011); step("R2 set core2");
    wr(1, 'h08, 32'h0000_0100); step("R2 set OR");
    wr(2, 'h08, 32'h0000_0000); step("R2 zero write");
    rd(3, 'h08); rd(0, 'h0A); step("R5 read core2");
    step("R5 read latency");

    // R4: non-message bits dropped
    wr(0, 'h04, 32'hEEEE_EEEE); step("R4 invalid bits");
    rd(1, 'h04); step("R4 read zero");
    wr(0, 'h04, 32'hFFFF_FFFF); rd(1, 'h04); step("R4 only valid kept");
    rd(1, 'h04); step("R4 readback");

    // R3: write-1-to-clear, clear word reads zero
    wr(2, 'h18, 32'h0000_0001); rd(3, 'h08); step("R3 clear msg0");
    rd(3, 'h08); rd(1, 'h18); step("R3 readback");
    wr(0, 'h14, 32'h0F0F_0F0F); step("R3 partial clear core1");
    rd(0, 'h04); rd(2, 'h14); step("R3 partial readback");

    // R7: set and clear of same bit in the same cycle
    wr(0, 'h00, 32'h0000_1000); wr(1, 'h10, 32'h0000_1000); step("R7 collision fresh");
    wr(2, 'h10, 32'h0000_1000); wr(3, 'h00, 32'h0000_1000); step("R7 collision held");
    rd(0, 'h00); step("R7 readback");

    // R8: several ports at one core
    wr(0, 'h0C, 32'h0000_0001); wr(1, 'h0C, 32'h0000_0010);
    wr(2, 'h0C, 32'h0010_0000); wr(3, 'h0C, 32'h1000_0000); step("R8 multi set");
    wr(0, 'h1C, 32'h0000_0001); wr(3, 'h1C, 32'h1000_0000); step("R8 multi clear");
    rd(2, 'h0C); step("R8 readback");

    // R9: out-of-range words
    wr(0, 'h20, 32'hFFFF_FFFF); wr(1, 'h3C, 32'hFFFF_FFFF); step("R9 write miss");
    rd(0, 'h20); rd(1, 'h3C); rd(2, 'h2C); step("R9 read miss");

    // R6: irq tracks each message bit
    for (int m = 0; m < NM; m++) begin
      wr(m % NC, 4 * (m % NC), 32'h1 << (4*m)); step("R6 irq set");
    end
    for (int m = 0; m < NM; m++) begin
      wr(m % NC, 'h10 + 4 * (m % NC), 32'h1 << (4*m)); step("R6 irq clear");
    end

    // R1: reset in mid-run
    wr(0, 'h00, VM); wr(1, 'h04, VM); step("R1 preload");
    r_i = 1'b1; rd(0, 'h00); step("R1 mid reset");
    r_i = 1'b0; rd(0, 'h00); step("R1 after mid reset");

    // random traffic across all ports
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NC; p++) begin
        a[p] = AW'($urandom_range(0, 2**AW - 1));
        w[p] = ($urandom_range(0, 2) != 0);
        d[p] = $urandom();
      end
      r_i = ($urandom_range(0, 499) == 0);
      step("R2 R3 R5 R6 R7 R8 random");
    end
    r_i = 1'b0;

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule